// File: doc/BRIEF.md
# Transmit/Receive Pin Switcher

This block drives four 16-bit banks of general-purpose pins that lead to plug-in radio boards. Each bit of a bank is either under software control or under automatic control, as chosen by a per-bank selection mask. A bit under software control takes its value from the bank's plain output register. A bit under automatic control takes one of two preset patterns. The transmit pattern is used while the transmit FIFO holds data. The receive pattern is used while that FIFO is empty. Antenna switches, amplifier enables and similar board controls therefore follow the data flow without any software action.

Software sets up the block through a write-only register bus with an address, a data word and a write strobe. Each bank has four registers: a selection mask, a transmit pattern, a receive pattern and a plain output word. The FIFO occupancy flag may come from another clock domain, so it passes through a synchronizer before it is used. The pins come from flops, and every bit of every bank is merged in parallel.

Top module: `atr_pin_switch`

## Requirements
- R1: While the reset is asserted, and after it is released, all 64 pins are 0 until software writes a register, because every register clears to 0.
- R2: For a bank whose mask bit is 1 and while the FIFO flag is 1 (nonempty), that pin equals the matching bit of the bank's transmit pattern.
- R3: For a bank whose mask bit is 1 and while the FIFO flag is 0 (empty), that pin equals the matching bit of the bank's receive pattern.
- R4: For a bank whose mask bit is 0, that pin equals the matching bit of the bank's plain output word, whatever the FIFO flag is.
- R5: The automatic-control registers of bank s (0 to 3) sit at ATR_BASE + 3*s (mask), +1 (transmit pattern) and +2 (receive pattern), with ATR_BASE = 8. Banks are ordered transmit side A = 0, receive side A = 1, transmit side B = 2, receive side B = 3. Bank s drives pins_out[16*s+15 : 16*s].
- R6: The plain output word of bank s sits at IO_BASE + s, with IO_BASE = 0.
- R7: A write to an address that maps to no register (4 to 7 and 20 to 63) changes no pin.
- R8: A change on fifo_nonempty that is set up before rising edge e reaches the pins at edge e+2 (two synchronizer flops and then the pin flop), and not before.
- R9: A register written at rising edge k shows at the pins after edge k+1, and not after edge k.
- R10: A write to one bank leaves the pins of the other three banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_addr | input | 6 | Register address |
| wr_data | input | 16 | Register write data |
| fifo_nonempty | input | 1 | 1 while the transmit FIFO holds data, may be asynchronous |
| pins_out | output | 64 | Registered pin values, bank s in bits 16*s+15 to 16*s |

## Verification
The case that is hardest to reach from the ports is a single bank that holds a mix of automatic and software bits while the FIFO flag toggles. Only then do both halves of the merge and the synchronizer lag all show in one word. The stimulus programs a bank with mask 0xF0F0 and different transmit, receive and plain words. It then flips the flag and samples the bank after each of the following edges. This shows that the pins hold their old value for two edges and take the new value on the third. Only the masked nibbles change.

// File: rtl/atr_pkg.sv
package atr_pkg;

  // Register kind within one bank's automatic-control triple
  typedef enum logic [1:0] {
    FLD_MASK  = 2'd0,
    FLD_TXPAT = 2'd1,
    FLD_RXPAT = 2'd2
  } atr_field_e;

  localparam int unsigned FIELDS_PER_BANK = 3;

  // Address of one automatic-control register of a bank
  function automatic int unsigned atr_reg_addr(input int unsigned base,
                                               input int unsigned bank,
                                               input atr_field_e  fld);
    return base + FIELDS_PER_BANK * bank + int'(fld);
  endfunction

  // Address of a bank's plain output word
  function automatic int unsigned io_reg_addr(input int unsigned base,
                                              input int unsigned bank);
    return base + bank;
  endfunction

endpackage

// File: rtl/atr_sync.sv
module atr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign sync_o = async_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], async_i};
        if (STAGES == 1) chain_d = async_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
      end

      assign sync_o = chain_q[STAGES-1];

      if (STAGES == 2) begin : g_chk
        logic [1:0] warm_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)              warm_q <= 2'd0;
          else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
        end

        AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n)
          (warm_q == 2'd2) |-> (sync_o == $past(async_i, 2))); // R8
      end
    end
  endgenerate

endmodule

// File: rtl/atr_regfile.sv
module atr_regfile
  import atr_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 16,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned IO_BASE   = 0,
  parameter int unsigned ATR_BASE  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [BANK_W-1:0]                 wr_data,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  mask_o,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  txpat_o,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  rxpat_o,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  io_o
);

  logic [NUM_BANKS-1:0][BANK_W-1:0] mask_q,  mask_d;
  logic [NUM_BANKS-1:0][BANK_W-1:0] txpat_q, txpat_d;
  logic [NUM_BANKS-1:0][BANK_W-1:0] rxpat_q, rxpat_d;
  logic [NUM_BANKS-1:0][BANK_W-1:0] io_q,    io_d;

  logic [NUM_BANKS-1:0] hit_mask, hit_tx, hit_rx, hit_io;
  logic                 hit_any;

  // One constant comparator per register
  generate
    for (genvar s = 0; s < NUM_BANKS; s++) begin : g_dec
      localparam int unsigned A_MASK = atr_reg_addr(ATR_BASE, s, FLD_MASK);
      localparam int unsigned A_TX   = atr_reg_addr(ATR_BASE, s, FLD_TXPAT);
      localparam int unsigned A_RX   = atr_reg_addr(ATR_BASE, s, FLD_RXPAT);
      localparam int unsigned A_IO   = io_reg_addr(IO_BASE, s);

      assign hit_mask[s] = (wr_addr == ADDR_W'(A_MASK));
      assign hit_tx[s]   = (wr_addr == ADDR_W'(A_TX));
      assign hit_rx[s]   = (wr_addr == ADDR_W'(A_RX));
      assign hit_io[s]   = (wr_addr == ADDR_W'(A_IO));

      AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_mask[s]) |=> (mask_q[s] == $past(wr_data))); // R5
      AST_IO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_io[s]) |=> (io_q[s] == $past(wr_data))); // R6
    end
  endgenerate

  assign hit_any = |{hit_mask, hit_tx, hit_rx, hit_io};

  // Next-state
  always_comb begin
    mask_d  = mask_q;
    txpat_d = txpat_q;
    rxpat_d = rxpat_q;
    io_d    = io_q;
    for (int s = 0; s < NUM_BANKS; s++) begin
      if (wr_en && hit_mask[s]) mask_d[s]  = wr_data;
      if (wr_en && hit_tx[s])   txpat_d[s] = wr_data;
      if (wr_en && hit_rx[s])   rxpat_d[s] = wr_data;
      if (wr_en && hit_io[s])   io_d[s]    = wr_data;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      txpat_q <= '0;
      rxpat_q <= '0;
      io_q    <= '0;
    end else if (wr_en) begin
      mask_q  <= mask_d;
      txpat_q <= txpat_d;
      rxpat_q <= rxpat_d;
      io_q    <= io_d;
    end
  end

  assign mask_o  = mask_q;
  assign txpat_o = txpat_q;
  assign rxpat_o = rxpat_q;
  assign io_o    = io_q;

  AST_UNMAPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit_any) |=> ($stable(mask_q) && $stable(txpat_q) &&
                             $stable(rxpat_q) && $stable(io_q))); // R7

endmodule

// File: rtl/atr_bank_mux.sv
module atr_bank_mux #(
  parameter int unsigned BANK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_active,
  input  logic [BANK_W-1:0] mask_i,
  input  logic [BANK_W-1:0] txpat_i,
  input  logic [BANK_W-1:0] rxpat_i,
  input  logic [BANK_W-1:0] io_i,
  output logic [BANK_W-1:0] pins_o
);

  logic [BANK_W-1:0] auto_val;
  logic [BANK_W-1:0] pins_d;
  logic [BANK_W-1:0] pins_q;

  // Next-state: per-bit merge
  always_comb begin
    auto_val = tx_active ? txpat_i : rxpat_i;
    pins_d   = (mask_i & auto_val) | (~mask_i & io_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pins_q <= '0;
    else        pins_q <= pins_d;
  end

  assign pins_o = pins_q;

  AST_TX_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_active) |->
      ((pins_q & $past(mask_i)) == ($past(txpat_i) & $past(mask_i)))); // R2
  AST_RX_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tx_active) |->
      ((pins_q & $past(mask_i)) == ($past(rxpat_i) & $past(mask_i)))); // R3
  AST_SW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pins_q & ~$past(mask_i)) == ($past(io_i) & ~$past(mask_i)))); // R4

endmodule

// File: rtl/atr_pin_switch.sv
module atr_pin_switch #(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned BANK_W      = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned IO_BASE     = 0,
  parameter int unsigned ATR_BASE    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [BANK_W-1:0]             wr_data,
  input  logic                          fifo_nonempty,
  output logic [NUM_BANKS*BANK_W-1:0]   pins_out
);

  localparam int unsigned PIN_W = NUM_BANKS * BANK_W;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic tx_active;

  atr_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (fifo_nonempty),
    .sync_o  (tx_active)
  );

  logic [NUM_BANKS-1:0][BANK_W-1:0] mask_w, txpat_w, rxpat_w, io_w;

  atr_regfile #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W),
    .IO_BASE   (IO_BASE),
    .ATR_BASE  (ATR_BASE)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mask_o  (mask_w),
    .txpat_o (txpat_w),
    .rxpat_o (rxpat_w),
    .io_o    (io_w)
  );

  logic [PIN_W-1:0] pins_w;

  generate
    for (genvar s = 0; s < NUM_BANKS; s++) begin : g_bank
      atr_bank_mux #(.BANK_W(BANK_W)) mux_i (
        .clk       (clk),
        .rst_n     (rst_core_n),
        .tx_active (tx_active),
        .mask_i    (mask_w[s]),
        .txpat_i   (txpat_w[s]),
        .rxpat_i   (rxpat_w[s]),
        .io_i      (io_w[s]),
        .pins_o    (pins_w[s*BANK_W +: BANK_W])
      );
    end
  endgenerate

  assign pins_out = pins_w;

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_core_n |=> (pins_out == '0)); // R1
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!$past(wr_en) && !wr_en && $stable(tx_active)) |=> $stable(pins_out)); // R10

endmodule

// File: tb/atr_pin_switch_tb_top.sv
`timescale 1ns/1ps
module atr_pin_switch_tb_top;

  localparam int BW = 16;
  localparam int NB = 4;
  localparam int IO_B = 0;
  localparam int ATR_B = 8;
  localparam int NV = 6;

  // Vector table: bank, mask, tx pattern, rx pattern, plain word, fifo flag, expected bank pins
  localparam int         V_BANK [NV] = '{0, 1, 2, 3, 0, 2};
  localparam logic [15:0] V_MASK [NV] = '{16'hFFFF, 16'h0000, 16'hFF00, 16'h00FF, 16'hF0F0, 16'h0FF0};
  localparam logic [15:0] V_TX   [NV] = '{16'hA5A5, 16'hFFFF, 16'hABCD, 16'h1111, 16'h0F0F, 16'h1248};
  localparam logic [15:0] V_RX   [NV] = '{16'h5A5A, 16'hFFFF, 16'h0000, 16'h2222, 16'hC3C3, 16'h8421};
  localparam logic [15:0] V_IO   [NV] = '{16'h1234, 16'h1234, 16'h1357, 16'h9999, 16'h3C3C, 16'hFFFF};
  localparam logic        V_FIFO [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [15:0] V_EXP  [NV] = '{16'hA5A5, 16'h1234, 16'hAB57, 16'h9922, 16'hCCCC, 16'hF24F};
  localparam string       V_REQ  [NV] = '{"R2 R5", "R4 R6", "R2 R4 R5", "R3 R4 R5", "R3 R4", "R2 R4"};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  wr_addr;
  logic [15:0] wr_data;
  logic        fifo_nonempty;
  logic [63:0] pins_out;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  atr_pin_switch dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .fifo_nonempty (fifo_nonempty),
    .pins_out      (pins_out)
  );

  function automatic logic [15:0] bank_pins(input int b);
    return pins_out[b*BW +: BW];
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [15:0] data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 6'(addr);
    wr_data = data;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] snap;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    fifo_nonempty = 1'b0;
    idle(3);
    chk("R1 in reset", pins_out, 64'h0);
    rst_n = 1'b1;
    idle(5);
    chk("R1 after release", pins_out, 64'h0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      wr(ATR_B + 3*V_BANK[v] + 0, V_MASK[v]);
      wr(ATR_B + 3*V_BANK[v] + 1, V_TX[v]);
      wr(ATR_B + 3*V_BANK[v] + 2, V_RX[v]);
      wr(IO_B + V_BANK[v], V_IO[v]);
      fifo_nonempty = V_FIFO[v];
      idle(4);
      chk(V_REQ[v], 64'(bank_pins(V_BANK[v])), 64'(V_EXP[v]));
    end

    // R7: unmapped addresses
    snap = pins_out;
    wr(5, 16'hFFFF);
    wr(40, 16'hFFFF);
    wr(63, 16'hFFFF);
    idle(2);
    chk("R7 unmapped writes", pins_out, snap);

    // R9 and R10: write bank 1 plain word (its mask is 0)
    snap = pins_out;
    wr(IO_B + 1, 16'hBEEF);
    chk("R9 not after write edge", 64'(bank_pins(1)), 64'h1234);
    idle(1);
    chk("R9 after next edge", 64'(bank_pins(1)), 64'hBEEF);
    snap[1*BW +: BW] = 16'hBEEF;
    chk("R10 other banks unchanged", pins_out, snap);

    // R8: FIFO flag lag on bank 0 (mask F0F0, tx 0F0F, rx C3C3, io 3C3C)
    chk("R8 start tx state", 64'(bank_pins(0)), 64'h0C0C);
    @(negedge clk);
    fifo_nonempty = 1'b0;
    idle(1);
    chk("R8 after one edge", 64'(bank_pins(0)), 64'h0C0C);
    idle(1);
    chk("R8 after two edges", 64'(bank_pins(0)), 64'h0C0C);
    idle(1);
    chk("R8 R3 after three edges", 64'(bank_pins(0)), 64'hCCCC);
    fifo_nonempty = 1'b1;
    idle(2);
    chk("R8 back not yet", 64'(bank_pins(0)), 64'hCCCC);
    idle(1);
    chk("R8 R2 back to tx", 64'(bank_pins(0)), 64'h0C0C);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    idle(1);
    chk("R1 mid-run reset", pins_out, 64'h0);
    rst_n = 1'b1;
    idle(6);
    chk("R1 registers cleared", pins_out, 64'h0);

    summary();
    $finish;
  end

endmodule